// File: doc/BRIEF.md
# DSP-Format Serial Audio Receiver

This block converts a two-channel serial PCM stream into parallel samples. The stream uses the late-frame DSP format. Its only clock is the serial bit clock, and it samples the frame-sync and data lines on every rising edge of that clock. A frame opens with a low-to-high change on frame sync. The data bit present on that same edge is already the most significant bit of the left word. The right word follows the left word at once, with no spare bit between them. Every bit clocked in after the right word's last bit is treated as filler until the next frame opens.

Each word is 16, 20 or 24 bits long, chosen by a two-bit select that is read once per frame. Samples come out left-justified in 24-bit registers, with the unused low bits cleared. Both channel registers change on the same edge and are marked by a one-cycle strobe. If a frame is cut short by a new sync edge, the partial frame is dropped and no output changes for it.

The control is a three-state machine:
- **IDLE**: waiting for a frame, ignoring data.
- **LEFT**: collecting left bits.
- **RIGHT**: collecting right bits.

Its transitions are:
- **START**: any state goes to LEFT on a sync rising edge. This also applies mid-frame, where it acts as the restart.
- **SWAP**: LEFT goes to RIGHT after the left word's last bit.
- **FINISH**: RIGHT goes to IDLE after the right word's last bit. This raises the done pulse.
- **HOLD**: every other case keeps the current state.

Top module: `dsp_late_rx`

## Requirements
- R1: A frame starts on a bit-clock rising edge where `fsync` is 1 and was 0 on the previous rising edge. The `sdata` bit sampled on that edge is the left word's MSB. A high `fsync` on the first edge after reset release does not start a frame.
- R2: Words are shifted MSB first. The left word comes first, and the right word's MSB follows on the edge after the left word's LSB.
- R3: `wlen_sel` sets the word length: 2'b00 = 16 bits, 2'b01 = 20 bits, and 2'b10 or 2'b11 = 24 bits. It is read only on the frame-start edge, so changing it later in the frame has no effect on that frame.
- R4: Each sample sits in bits [23:24-N] of its 24-bit output, where N is the word length, and the remaining low bits are 0.
- R5: `sample_valid` is high for exactly one cycle, right after the edge that captures the right word's LSB. `left_q` and `right_q` change on that same edge and at no other time except reset.
- R6: Bits after the right word's LSB, up to the next frame start, do not change any output.
- R7: A sync rising edge before the right word's LSB has been captured drops the partial frame. This includes the edge where that LSB would arrive. No valid pulse is given for the dropped frame, and capture restarts at the left MSB.
- R8: With `rst_n` low on a rising edge, `left_q`, `right_q` and `sample_valid` become 0 and the machine returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; its rising edge marks the left MSB |
| sdata | input | 1 | Serial data, MSB first |
| wlen_sel | input | 2 | Word length select, read at frame start |
| left_q | output | 24 | Left sample, left-justified |
| right_q | output | 24 | Right sample, left-justified |
| sample_valid | output | 1 | One-cycle strobe when a new sample pair is available |

## Verification
The assertions assume that a frame is never shorter than two full words plus one filler bit. This guarantees that two valid strobes cannot fall on adjacent edges. They also assume that `fsync` and `sdata` are stable around each rising edge. The bench drives every input on the falling edge and always places filler bits after a complete frame. The only early sync edges it produces are the deliberate mid-frame restarts. Those never yield a strobe, so the one-cycle pulse and output-hold properties stay within what the assertions assume.

// File: rtl/dsprx_pkg.sv
package dsprx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_t;

    // Word length in bits for a select code; reserved code maps to 24.
    function automatic int unsigned wlen_bits(input logic [1:0] sel);
        int unsigned n;
        unique case (sel)
            2'b00:   n = 16;
            2'b01:   n = 20;
            default: n = 24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dsprx_sync_edge.sv
module dsprx_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic rise
);
    logic fsync_prev;

    // Reset value 1: a sync already high at release is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) fsync_prev <= 1'b1;
        else        fsync_prev <= fsync;
    end

    assign rise = fsync & ~fsync_prev;
endmodule

// File: rtl/dsprx_ctrl.sv
module dsprx_ctrl
    import dsprx_pkg::*;
#(
    parameter int DATA_W = 24,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [1:0]       wlen_sel,
    output logic             clr,
    output logic             left_we,
    output logic             right_we,
    output logic [CNT_W-1:0] idx,
    output logic             done,
    output logic [CNT_W:0]   frame_wl
);
    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   wl_q, wl_d;
    logic             last_bit;

    assign last_bit = ({1'b0, cnt_q} == (wl_q - 1'b1));
    assign frame_wl = wl_q;

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wl_q    <= (CNT_W+1)'(DATA_W);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wl_q    <= wl_d;
        end
    end

    // Next-state and output process.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wl_d     = wl_q;
        clr      = 1'b0;
        left_we  = 1'b0;
        right_we = 1'b0;
        done     = 1'b0;
        idx      = cnt_q;
        if (rise) begin
            // START: this edge's bit is the left MSB
            clr      = 1'b1;
            left_we  = 1'b1;
            idx      = '0;
            state_d  = ST_LEFT;
            cnt_d    = CNT_W'(1);
            wl_d     = (CNT_W+1)'(wlen_bits(wlen_sel));
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    // HOLD: filler bits ignored
                end
                ST_LEFT: begin
                    left_we = 1'b1;
                    if (last_bit) begin
                        state_d = ST_RIGHT;   // SWAP
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
                ST_RIGHT: begin
                    right_we = 1'b1;
                    if (last_bit) begin
                        done    = 1'b1;       // FINISH
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dsprx_word.sv
module dsprx_word #(
    parameter int DATA_W = 24,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [CNT_W-1:0]  idx,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word_q,
    output logic [DATA_W-1:0] word_d
);
    logic [CNT_W-1:0] pos;

    // Bit index 0 lands in the MSB, giving left-justified words.
    assign pos = CNT_W'(DATA_W - 1) - idx;

    always_comb begin
        word_d = clr ? '0 : word_q;
        if (we) word_d[pos] = bit_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/dsprx_outreg.sv
module dsprx_outreg #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    output logic [DATA_W-1:0] left_q,
    output logic [DATA_W-1:0] right_q,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= load;
            if (load) begin
                left_q  <= left_in;
                right_q <= right_in;
            end
        end
    end
endmodule

// File: rtl/dsp_late_rx.sv
module dsp_late_rx #(
    parameter int DATA_W = 24
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              sdata,
    input  logic [1:0]        wlen_sel,
    output logic [DATA_W-1:0] left_q,
    output logic [DATA_W-1:0] right_q,
    output logic              sample_valid
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int N_CH  = 2;

    logic             rise;
    logic             clr;
    logic             left_we;
    logic             right_we;
    logic             done;
    logic [CNT_W-1:0] idx;
    logic [CNT_W:0]   frame_wl;
    logic [N_CH-1:0]  ch_we;
    logic [DATA_W-1:0] ch_q [N_CH];
    logic [DATA_W-1:0] ch_d [N_CH];

    dsprx_sync_edge u_edge (
        .clk   (bclk),
        .rst_n (rst_n),
        .fsync (fsync),
        .rise  (rise)
    );

    dsprx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (bclk),
        .rst_n    (rst_n),
        .rise     (rise),
        .wlen_sel (wlen_sel),
        .clr      (clr),
        .left_we  (left_we),
        .right_we (right_we),
        .idx      (idx),
        .done     (done),
        .frame_wl (frame_wl)
    );

    assign ch_we = {right_we, left_we};

    // Channel 0 = left, channel 1 = right.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dsprx_word #(.DATA_W(DATA_W)) u_word (
            .clk    (bclk),
            .rst_n  (rst_n),
            .clr    (clr),
            .we     (ch_we[c]),
            .idx    (idx),
            .bit_in (sdata),
            .word_q (ch_q[c]),
            .word_d (ch_d[c])
        );
    end

    // Right word includes the LSB captured on the load edge.
    dsprx_outreg #(.DATA_W(DATA_W)) u_out (
        .clk      (bclk),
        .rst_n    (rst_n),
        .load     (done),
        .left_in  (ch_q[0]),
        .right_in (ch_d[1]),
        .left_q   (left_q),
        .right_q  (right_q),
        .valid    (sample_valid)
    );
endmodule

// File: rtl/dsprx_checker.sv
module dsprx_checker #(
    parameter int DATA_W = 24,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              sample_valid,
    input logic [DATA_W-1:0] left_q,
    input logic [DATA_W-1:0] right_q,
    input logic [CNT_W:0]    frame_wl
);
    logic was_rst;

    always_ff @(posedge clk) was_rst <= !rst_n;

    // R8: the edge after a reset edge shows cleared outputs
    always @(posedge clk) begin
        if (was_rst === 1'b1) begin
            assert_reset_clear_R8: assert (!sample_valid && left_q == '0 && right_q == '0)
                else $error("reset did not clear outputs");
        end
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    assert_done_to_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> sample_valid);

    assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$rose(sample_valid)) |-> ($stable(left_q) && $stable(right_q)));

    assert_zero_lsb16_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && frame_wl == (CNT_W+1)'(16)) |->
            (left_q[DATA_W-17:0] == '0 && right_q[DATA_W-17:0] == '0));

    assert_zero_lsb20_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && frame_wl == (CNT_W+1)'(20)) |->
            (left_q[DATA_W-21:0] == '0 && right_q[DATA_W-21:0] == '0));
endmodule

bind dsp_late_rx dsprx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (bclk),
    .rst_n        (rst_n),
    .done         (done),
    .sample_valid (sample_valid),
    .left_q       (left_q),
    .right_q      (right_q),
    .frame_wl     (frame_wl)
);

// File: tb/dsp_late_rx_test.sv
`timescale 1ns/1ps
module dsp_late_rx_test;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  wlen_sel = 2'b00;
    logic [23:0] left_q, right_q;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    int vcount = 0;

    always #2.5 bclk = ~bclk;

    dsp_late_rx uut (
        .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
        .wlen_sel(wlen_sel), .left_q(left_q), .right_q(right_q),
        .sample_valid(sample_valid)
    );

    always @(negedge bclk) if (sample_valid === 1'b1) vcount++;

    // {wlen_sel, left, right}
    localparam int NV = 6;
    localparam logic [49:0] VEC [NV] = '{
        {2'b00, 24'hA5C3FF, 24'h3C5A11},
        {2'b01, 24'h81234F, 24'hFEDCBA},
        {2'b10, 24'hC0FFEE, 24'h123456},
        {2'b11, 24'h7FFFFF, 24'h800001},
        {2'b00, 24'hFFFFFF, 24'h000000},
        {2'b10, 24'h000001, 24'hFFFFFE}
    };

    function automatic int wl_of(input logic [1:0] s);
        return (s == 2'b00) ? 16 : (s == 2'b01) ? 20 : 24;
    endfunction

    function automatic logic [23:0] mask_of(input logic [1:0] s);
        return 24'hFFFFFF << (24 - wl_of(s));
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives nsend bits of a frame; word length taken from ws for bit order.
    task automatic send_frame(input logic [1:0] ws, input logic [1:0] ws_after,
                              input logic [23:0] l, input logic [23:0] r, input int nsend);
        int n = wl_of(ws);
        for (int i = 0; i < nsend; i++) begin
            @(negedge bclk);
            fsync    = (i == 0);
            wlen_sel = (i == 0) ? ws : ws_after;
            sdata    = (i < n) ? l[23-i] : r[23-(i-n)];
        end
    endtask

    task automatic idle(input int n, input logic pat);
        for (int i = 0; i < n; i++) begin
            @(negedge bclk);
            fsync = 1'b0;
            sdata = pat ^ i[0];
        end
    endtask

    // Samples the strobe edge after a full frame, then the pulse end.
    task automatic expect_pair(input string req, input logic [23:0] el, input logic [23:0] er);
        @(negedge bclk);
        check(req, {47'd0, sample_valid}, 48'd1);
        check(req, {left_q, right_q}, {el, er});
        fsync = 1'b0;
        sdata = 1'b1;
        @(negedge bclk);
        check("R5 pulse", {47'd0, sample_valid}, 48'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        logic [23:0] hl, hr;
        repeat (3) @(negedge bclk);
        check("R8 reset state", {left_q, right_q}, 48'd0);
        check("R8 reset valid", {47'd0, sample_valid}, 48'd0);
        rst_n = 1'b1;
        idle(3, 1'b0);

        // Vector table: R1, R2, R3, R4 under several patterns
        for (int k = 0; k < NV; k++) begin
            logic [1:0]  ws = VEC[k][49:48];
            logic [23:0] l  = VEC[k][47:24];
            logic [23:0] r  = VEC[k][23:0];
            send_frame(ws, ws, l, r, 2 * wl_of(ws));
            expect_pair("R2 R3 R4 vector", l & mask_of(ws), r & mask_of(ws));
            hl = left_q; hr = right_q; v0 = vcount;
            idle(20, k[0]);
            check("R6 filler ignored", {left_q, right_q}, {hl, hr});
            check("R6 no strobe", v0, vcount);
        end

        // R3: select changed after frame start is ignored
        send_frame(2'b00, 2'b10, 24'h13579B, 24'h2468AC, 32);
        expect_pair("R3 latched select", 24'h135700, 24'h246800);
        idle(4, 1'b1);

        // R7: restart mid-left
        v0 = vcount;
        send_frame(2'b10, 2'b10, 24'hDEAD00, 24'hBEEF00, 10);
        send_frame(2'b01, 2'b01, 24'h55AA55, 24'hAA55AA, 40);
        expect_pair("R7 restart mid-left", 24'h55AA50, 24'hAA55A0);
        check("R7 single strobe", vcount - v0, 1);
        idle(4, 1'b0);

        // R7: new sync edge lands where right LSB would be
        v0 = vcount;
        send_frame(2'b00, 2'b00, 24'h111100, 24'h222200, 31);
        send_frame(2'b00, 2'b00, 24'h9ABC00, 24'hDEF000, 32);
        expect_pair("R7 restart at right LSB", 24'h9ABC00, 24'hDEF000);
        check("R7 dropped frame no strobe", vcount - v0, 1);
        idle(4, 1'b0);

        // R8: reset in mid-frame clears outputs
        send_frame(2'b10, 2'b10, 24'hABCDEF, 24'h123456, 12);
        @(negedge bclk);
        rst_n = 1'b0;
        @(negedge bclk);
        check("R8 mid-frame reset", {47'd0, sample_valid, left_q, right_q} , 48'd0);

        // R1: sync high at reset release is not a frame start
        fsync = 1'b1;
        @(negedge bclk);
        rst_n = 1'b1;
        v0 = vcount;
        for (int i = 0; i < 60; i++) begin
            @(negedge bclk);
            sdata = i[1];
        end
        check("R1 no start on high sync at release", vcount - v0, 0);
        check("R1 outputs unchanged", {left_q, right_q}, 48'd0);
        idle(2, 1'b0);
        send_frame(2'b00, 2'b00, 24'h8001FF, 24'h0180FF, 32);
        expect_pair("R1 first start after release", 24'h800100, 24'h018000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule